// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which peripheral request the core services next. Each source has a flag. The flag latches whenever the source's condition appears, whatever the enables hold at that moment. A source is eligible only when its flag, its own enable bit and the global enable are all set.

Every source carries a two-bit priority. Among eligible sources the highest priority wins, and a tie goes to the lowest source index. The winner is taken only at an instruction boundary. When it is taken, the block raises a vector request with the handler address and holds it until the core reports that the call has completed.

A stack of in-service bits, one per priority level, lets a handler be preempted only by a request of strictly higher priority. A return strobe retires the innermost level. Each source is built either as a pulse source (flag set on a rising input) or as a level source (flag set in every cycle the input is high). Pulse sources listed in a parameter mask lose their flag automatically when their vector is taken.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `vec_valid` is 0 and no priority level is in service.
- R2: A flag sets whatever the source enable and global enable hold. For a pulse source it sets only on a 0-to-1 change of its input. For a level source it sets in every cycle the input is 1. Flags read at address 1, with bit i for source i.
- R3: Writing address 1 clears each flag whose data bit is 1. A set condition in the same cycle wins over the clear, so a level source with its input still high keeps its flag.
- R4: Address 0 holds one enable bit per source in bits NUM_SRC-1:0. Bits above the sources read 0. Address 2 bit 0 is the global enable. All of these reset to 0.
- R5: When `insn_bound` is 1, no vector is outstanding and an eligible request exists, `vec_valid` rises on the next clock with `vec_addr` = VEC_BASE + 8 × source index.
- R6: The taken request is the eligible one with the highest priority value (3 is highest). Ties go to the lowest source index.
- R7: While any level is in service, only a request whose priority is strictly above the highest in-service level can be taken. Each take marks its level in service.
- R8: A `reti` pulse clears the highest in-service level. A pending request that was blocked is then taken at the next eligible boundary.
- R9: Sources in AUTO_CLR_MASK lose their flag in the cycle their vector is taken. All other flags stay set until they are cleared through R3.
- R10: Once `vec_valid` is 1, it and `vec_addr` hold steady until a clock with `call_done` = 1. No new request is taken while it is 1.
- R11: With the global enable at 0, no request is taken, but flags keep latching.
- R12: Priorities are 2-bit fields. Address 3 holds sources 0–3 and address 4 holds sources 4–5, with source k at bits 2·(k mod 4)+1:2·(k mod 4). Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_evt | input | NUM_SRC | Source condition inputs |
| insn_bound | input | 1 | Instruction-boundary strobe from the core |
| call_done | input | 1 | Core has completed the vectored call |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | Vector request outstanding |
| vec_addr | output | VEC_W | Handler address of the taken source |

## Verification
The bench aims at four corner cases:
- An equal-priority request that arrives while a handler runs must stay pending. A controller that compares with "greater or equal" would nest it at once.
- After two nested takes, a return must retire only the inner level. Clearing all in-service bits would let the blocked equal-level request in one return too early.
- Clearing a flag while a level input is still high must leave the flag set. Clearing a pulse flag while its input stays high must not bring it back. A wrong clear/set precedence breaks one of the two.
- Auto-clear must hit only the taken source. Random traffic with reprogrammed priorities and partially masked enables checks that the tie-break and the held vector never drift.

// File: rtl/nic_pkg.sv
package nic_pkg;

   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_ENABLE = 3'd0,
      RA_FLAGS  = 3'd1,
      RA_CTRL   = 3'd2,
      RA_PRIO0  = 3'd3
   } reg_addr_e;

endpackage

// File: rtl/nic_src_flag.sv
module nic_src_flag #(
   parameter bit IS_LEVEL = 1'b0,
   parameter bit AUTO_CLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic sw_clr,
   input  logic vec_taken,
   output logic flag
);

   logic set_now;
   logic auto_hit;

   assign auto_hit = vec_taken & AUTO_CLR;

   generate
      if (IS_LEVEL) begin : g_level
         assign set_now = evt;
      end else begin : g_pulse
         logic evt_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_d <= 1'b0;
            else        evt_d <= evt;
         end
         assign set_now = evt & ~evt_d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~sw_clr & ~auto_hit) | set_now;
   end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
   parameter int NUM_SRC = 6,
   parameter int PRIO_W  = 2,
   parameter int SRC_W   = 3
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic                      floor_vld,
   input  logic [PRIO_W-1:0]         floor_lvl,
   output logic                      win_vld,
   output logic [SRC_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_lvl
);

   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req[i]
             && (!floor_vld || prio_flat[i*PRIO_W +: PRIO_W] > floor_lvl)
             && (!win_vld   || prio_flat[i*PRIO_W +: PRIO_W] > win_lvl)) begin
            win_vld = 1'b1;
            win_idx = SRC_W'(i);
            win_lvl = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/nic_isr_track.sv
module nic_isr_track #(
   parameter int PRIO_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic [PRIO_W-1:0]       push_lvl,
   input  logic                    pop,
   output logic [(1<<PRIO_W)-1:0]  isr,
   output logic                    busy,
   output logic [PRIO_W-1:0]       top_lvl
);

   localparam int NUM_LVL = 1 << PRIO_W;
   localparam logic [NUM_LVL-1:0] ONE = {{(NUM_LVL-1){1'b0}}, 1'b1};

   logic [NUM_LVL-1:0] pop_mask;
   logic [NUM_LVL-1:0] push_mask;

   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (isr[l]) top_lvl = PRIO_W'(l);
      end
   end

   assign busy      = |isr;
   assign pop_mask  = (pop && busy) ? (ONE << top_lvl) : '0;
   assign push_mask = push ? (ONE << push_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~pop_mask) | push_mask;
   end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int                 NUM_SRC       = 6,
   parameter int                 PRIO_W        = 2,
   parameter int                 VEC_W         = 16,
   parameter int unsigned        VEC_BASE      = 3,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK    = 6'b010010,
   parameter logic [NUM_SRC-1:0] AUTO_CLR_MASK = 6'b000000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   input  logic [NUM_SRC-1:0]    src_evt,
   input  logic                  insn_bound,
   input  logic                  call_done,
   input  logic                  reti,
   output logic                  vec_valid,
   output logic [VEC_W-1:0]      vec_addr
);

   localparam int NUM_LVL       = 1 << PRIO_W;
   localparam int SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int FLD_PER_BYTE  = 8 / PRIO_W;
   localparam int NUM_PRI_BYTES = (NUM_SRC + FLD_PER_BYTE - 1) / FLD_PER_BYTE;

   // elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > 8) begin : g_bad_nsrc
      $error("nest_irq_ctrl: NUM_SRC must be 2..8");
   end
   if (PRIO_W != 1 && PRIO_W != 2 && PRIO_W != 4) begin : g_bad_prio
      $error("nest_irq_ctrl: PRIO_W must be 1, 2 or 4");
   end
   if (int'(RA_PRIO0) + NUM_PRI_BYTES > (1 << REG_ADDR_W)) begin : g_bad_map
      $error("nest_irq_ctrl: priority bytes exceed address space");
   end
   if ((LEVEL_MASK & AUTO_CLR_MASK) != '0) begin : g_bad_mask
      $error("nest_irq_ctrl: level sources cannot be auto-cleared");
   end
   if (VEC_W < 4 || VEC_W > 32) begin : g_bad_vw
      $error("nest_irq_ctrl: VEC_W must be 4..32");
   end

   logic [NUM_SRC-1:0]        en_q;
   logic                      gie_q;
   logic [NUM_SRC-1:0]        flag_vec;
   logic [NUM_SRC-1:0]        req;
   logic [NUM_SRC-1:0]        sw_clr;
   logic [NUM_SRC-1:0]        taken;
   logic [PRIO_W-1:0]         prio_q [NUM_SRC];
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [7:0]                pri_rd [NUM_PRI_BYTES];

   logic                      win_vld;
   logic [SRC_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_lvl;
   logic                      ack;

   logic [NUM_LVL-1:0]        isr_bits;
   logic                      isr_busy;
   logic [PRIO_W-1:0]         isr_top;

   logic                      vec_valid_q;
   logic [VEC_W-1:0]          vec_addr_q;

   logic                      wr_flags;

   assign wr_flags = reg_wr && (reg_addr == RA_FLAGS);

   // per-source flag cells and priority fields
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      nic_src_flag #(
         .IS_LEVEL (LEVEL_MASK[i]),
         .AUTO_CLR (AUTO_CLR_MASK[i])
      ) u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt       (src_evt[i]),
         .sw_clr    (sw_clr[i]),
         .vec_taken (taken[i]),
         .flag      (flag_vec[i])
      );

      assign sw_clr[i] = wr_flags & reg_wdata[i];
      assign taken[i]  = ack && (win_idx == SRC_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[i] <= '0;
         else if (reg_wr && reg_addr == REG_ADDR_W'(int'(RA_PRIO0) + i / FLD_PER_BYTE))
            prio_q[i] <= reg_wdata[(i % FLD_PER_BYTE)*PRIO_W +: PRIO_W];
      end

      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   // enable and global-enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         gie_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == RA_ENABLE) en_q  <= reg_wdata[NUM_SRC-1:0];
         if (reg_addr == RA_CTRL)   gie_q <= reg_wdata[0];
      end
   end

   assign req = flag_vec & en_q & {NUM_SRC{gie_q}};

   nic_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .SRC_W   (SRC_W)
   ) u_arb (
      .req       (req),
      .prio_flat (prio_flat),
      .floor_vld (isr_busy),
      .floor_lvl (isr_top),
      .win_vld   (win_vld),
      .win_idx   (win_idx),
      .win_lvl   (win_lvl)
   );

   assign ack = insn_bound && !vec_valid_q && win_vld;

   nic_isr_track #(
      .PRIO_W (PRIO_W)
   ) u_isr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack),
      .push_lvl (win_lvl),
      .pop      (reti),
      .isr      (isr_bits),
      .busy     (isr_busy),
      .top_lvl  (isr_top)
   );

   // vector request held until the call completes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_q <= 1'b0;
         vec_addr_q  <= '0;
      end else if (ack) begin
         vec_valid_q <= 1'b1;
         vec_addr_q  <= VEC_W'(VEC_BASE) + (VEC_W'(win_idx) << 3);
      end else if (call_done) begin
         vec_valid_q <= 1'b0;
      end
   end

   assign vec_valid = vec_valid_q;
   assign vec_addr  = vec_addr_q;

   // register read mux
   always_comb begin
      for (int b = 0; b < NUM_PRI_BYTES; b++) pri_rd[b] = '0;
      for (int i = 0; i < NUM_SRC; i++)
         pri_rd[i / FLD_PER_BYTE][(i % FLD_PER_BYTE)*PRIO_W +: PRIO_W] = prio_q[i];

      reg_rdata = '0;
      if (reg_addr == RA_ENABLE)
         reg_rdata[NUM_SRC-1:0] = en_q;
      else if (reg_addr == RA_FLAGS)
         reg_rdata[NUM_SRC-1:0] = flag_vec;
      else if (reg_addr == RA_CTRL)
         reg_rdata[0] = gie_q;
      else begin
         for (int b = 0; b < NUM_PRI_BYTES; b++)
            if (reg_addr == REG_ADDR_W'(int'(RA_PRIO0) + b)) reg_rdata = pri_rd[b];
      end
   end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter int                 NUM_SRC    = 6,
   parameter int                 PRIO_W     = 2,
   parameter int                 VEC_W      = 16,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   insn_bound,
   input logic                   call_done,
   input logic                   reti,
   input logic [NUM_SRC-1:0]     src_evt,
   input logic [NUM_SRC-1:0]     flags,
   input logic                   vec_valid,
   input logic [VEC_W-1:0]       vec_addr,
   input logic                   gie,
   input logic                   ack,
   input logic [(1<<PRIO_W)-1:0] isr
);

   // R10: vector request and address hold until the call completes
   p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && !call_done) |=> (vec_valid && $stable(vec_addr)));

   // R5: a new vector appears only after an instruction boundary
   p_take_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_valid) |-> $past(insn_bound));

   // R11: nothing is taken while the global enable is off
   p_no_take_gie_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_valid) |-> $past(gie));

   // R7: a take nests a level strictly above all in service, adding one bit
   p_nest_adds_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !reti) |=> ($countones(isr) == $countones($past(isr)) + 1));

   // R8: a return retires exactly one in-service level
   p_return_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && isr != '0 && !ack) |=> ($countones(isr) == $countones($past(isr)) - 1));

   // R2: flags latch on their condition regardless of enables
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag_chk
      if (LEVEL_MASK[i]) begin : g_lvl
         p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> flags[i]);
      end else begin : g_pls
         p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (src_evt[i] && !$past(src_evt[i])) |=> flags[i]);
      end
   end

endmodule

bind nest_irq_ctrl nic_checker #(
   .NUM_SRC    (NUM_SRC),
   .PRIO_W     (PRIO_W),
   .VEC_W      (VEC_W),
   .LEVEL_MASK (LEVEL_MASK)
) u_nic_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bound (insn_bound),
   .call_done  (call_done),
   .reti       (reti),
   .src_evt    (src_evt),
   .flags      (flag_vec),
   .vec_valid  (vec_valid),
   .vec_addr   (vec_addr),
   .gie        (gie_q),
   .ack        (ack),
   .isr        (isr_bits)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;

   localparam int          N    = 6;
   localparam logic [5:0]  LVL  = 6'b010010;
   localparam logic [5:0]  AUTO = 6'b100100;
   localparam int unsigned BASE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [5:0]  src_evt = '0;
   logic        insn_bound = 1'b0;
   logic        call_done = 1'b0;
   logic        reti = 1'b0;
   logic        vec_valid;
   logic [15:0] vec_addr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   nest_irq_ctrl #(
      .NUM_SRC       (N),
      .PRIO_W        (2),
      .VEC_W         (16),
      .VEC_BASE      (BASE),
      .LEVEL_MASK    (LVL),
      .AUTO_CLR_MASK (AUTO)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .src_evt    (src_evt),
      .insn_bound (insn_bound),
      .call_done  (call_done),
      .reti       (reti),
      .vec_valid  (vec_valid),
      .vec_addr   (vec_addr)
   );

   // reference model state
   logic [5:0]  m_en, m_flag, m_prev;
   logic        m_gie;
   logic [1:0]  m_prio [N];
   logic [3:0]  m_isr;
   logic        m_vv;
   logic [15:0] m_va;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0:    return {2'b00, m_en};
         3'd1:    return {2'b00, m_flag};
         3'd2:    return {7'b0, m_gie};
         3'd3:    return {m_prio[3], m_prio[2], m_prio[1], m_prio[0]};
         3'd4:    return {4'b0, m_prio[5], m_prio[4]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset();
      m_en = '0; m_flag = '0; m_prev = '0; m_gie = 1'b0;
      for (int i = 0; i < N; i++) m_prio[i] = '0;
      m_isr = '0; m_vv = 1'b0; m_va = '0;
   endtask

   // check outputs, then advance the model by one clock edge
   task automatic cycle();
      int cur, w, wl;
      bit ack;
      logic [5:0] set, clr, n_flag;
      logic [3:0] n_isr;
      #1;
      chk(reg_rdata === m_read(reg_addr), "R2/R4/R12 readback", reg_rdata, m_read(reg_addr));
      chk(vec_valid === m_vv, "R5/R10 vec_valid", vec_valid, m_vv);
      if (m_vv) chk(vec_addr === m_va, "R10 vec_addr", vec_addr, m_va);
      cur = -1;
      for (int l = 0; l < 4; l++) if (m_isr[l]) cur = l;
      w = -1; wl = -1;
      for (int i = 0; i < N; i++)
         if (m_flag[i] && m_en[i] && m_gie && int'(m_prio[i]) > cur && int'(m_prio[i]) > wl) begin
            w = i; wl = int'(m_prio[i]);
         end
      ack = insn_bound && !m_vv && (w >= 0);
      set = (src_evt & LVL) | (src_evt & ~m_prev & ~LVL);
      clr = (reg_wr && reg_addr == 3'd1) ? reg_wdata[5:0] : 6'b0;
      if (ack && AUTO[w]) clr[w] = 1'b1;
      n_flag = (m_flag & ~clr) | set;
      n_isr = m_isr;
      if (reti && cur >= 0) n_isr[cur] = 1'b0;
      if (ack) n_isr[wl] = 1'b1;
      @(posedge clk);
      #1;
      m_flag = n_flag;
      m_prev = src_evt;
      m_isr  = n_isr;
      if (ack) begin
         m_vv = 1'b1;
         m_va = 16'(BASE + 8 * w);
      end else if (call_done) m_vv = 1'b0;
      if (reg_wr) begin
         case (reg_addr)
            3'd0: m_en  = reg_wdata[5:0];
            3'd2: m_gie = reg_wdata[0];
            3'd3: for (int i = 0; i < 4; i++) m_prio[i] = reg_wdata[2*i +: 2];
            3'd4: for (int i = 0; i < 2; i++) m_prio[4+i] = reg_wdata[2*i +: 2];
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic idle();
      reg_wr = 1'b0; src_evt = '0; insn_bound = 1'b0; call_done = 1'b0; reti = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cycle();
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      logic [7:0] rd;
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register and the vector request
      for (int a = 0; a < 8; a++) begin
         peek(3'(a), rd);
         chk(rd === 8'h00, "R1 reset register", rd, 8'h00);
      end
      chk(vec_valid === 1'b0, "R1 reset vec_valid", vec_valid, 1'b0);
      cycle();

      // R4: unused enable bits read 0
      wr(3'd0, 8'hFF);
      peek(3'd0, rd);
      chk(rd === 8'h3F, "R4 enable unused bits", rd, 8'h3F);
      wr(3'd0, 8'h00);

      // R2/R3: pulse source 0 and level source 1 held high, enables off
      src_evt = 6'b000011;
      reg_addr = 3'd1;
      repeat (3) cycle();
      peek(3'd1, rd);
      chk(rd === 8'h03, "R2 flags latch while disabled", rd, 8'h03);
      wr(3'd1, 8'h03);
      peek(3'd1, rd);
      chk(rd === 8'h02, "R3 level keeps flag, pulse stays clear", rd, 8'h02);
      src_evt = '0;
      wr(3'd1, 8'h02);
      peek(3'd1, rd);
      chk(rd === 8'h00, "R3 write-one clear", rd, 8'h00);

      // R11: flag set and enabled, global enable off -> no take
      src_evt = 6'b000001; cycle(); src_evt = '0;
      wr(3'd0, 8'h01);
      insn_bound = 1'b1;
      repeat (3) cycle();
      chk(vec_valid === 1'b0, "R11 no take with global enable off", vec_valid, 1'b0);
      insn_bound = 1'b0;
      wr(3'd2, 8'h01);
      // R5: take at boundary, vector = base + 8*0
      insn_bound = 1'b1; cycle(); insn_bound = 1'b0;
      chk(vec_valid === 1'b1, "R5 take raises vec_valid", vec_valid, 1'b1);
      chk(vec_addr === 16'd3, "R5 vector address source 0", vec_addr, 16'd3);
      call_done = 1'b1; cycle(); call_done = 1'b0;
      wr(3'd1, 8'h01);
      reti = 1'b1; cycle(); reti = 1'b0;

      // R12: priority fields: src2=1, src3=1, src5=2
      wr(3'd3, 8'h50);
      wr(3'd4, 8'h08);
      peek(3'd4, rd);
      chk(rd === 8'h08, "R12 priority byte 1", rd, 8'h08);
      wr(3'd0, 8'h3F);

      // R6: src2 and src3 tie at level 1, lowest index wins
      src_evt = 6'b001100; cycle(); src_evt = '0;
      insn_bound = 1'b1; cycle();
      chk(vec_addr === 16'd19, "R6 tie goes to lowest index", vec_addr, 16'd19);
      // R9: auto-clear only for the taken source 2
      peek(3'd1, rd);
      chk(rd === 8'h08, "R9 auto-clear of taken source only", rd, 8'h08);
      call_done = 1'b1; cycle(); call_done = 1'b0;

      // R7: equal level pending source 3 must wait
      repeat (3) cycle();
      chk(vec_valid === 1'b0, "R7 equal level does not preempt", vec_valid, 1'b0);
      src_evt = 6'b100000; cycle(); src_evt = '0;
      cycle();
      chk(vec_addr === 16'd43, "R7 higher level preempts", vec_addr, 16'd43);
      // R10: held across boundaries until call_done
      src_evt = 6'b000001; cycle(); src_evt = '0; cycle();
      chk(vec_valid === 1'b1 && vec_addr === 16'd43, "R10 vector held", vec_addr, 16'd43);
      call_done = 1'b1; insn_bound = 1'b0; cycle(); call_done = 1'b0;
      wr(3'd1, 8'h01);

      // R8: first return leaves level 1 in service, second releases source 3
      reti = 1'b1; cycle(); reti = 1'b0;
      insn_bound = 1'b1; cycle();
      chk(vec_valid === 1'b0, "R8 inner return keeps outer level", vec_valid, 1'b0);
      insn_bound = 1'b0;
      reti = 1'b1; cycle(); reti = 1'b0;
      insn_bound = 1'b1; cycle(); insn_bound = 1'b0;
      chk(vec_addr === 16'd27, "R8 blocked request taken after return", vec_addr, 16'd27);
      call_done = 1'b1; cycle(); call_done = 1'b0;
      wr(3'd1, 8'h08);
      reti = 1'b1; cycle(); reti = 1'b0;

      // random traffic against the model (R2..R12)
      for (int c = 0; c < 4000; c++) begin
         idle();
         src_evt    = (($urandom % 6) == 0) ? 6'($urandom) : 6'b0;
         insn_bound = ($urandom % 2) == 0;
         call_done  = m_vv && (($urandom % 3) == 0);
         reti       = ($urandom % 8) == 0;
         reg_addr   = 3'($urandom % 6);
         if (($urandom % 6) == 0) begin
            reg_wr    = 1'b1;
            reg_wdata = 8'($urandom);
            if (reg_addr == 3'd2) reg_wdata[0] = ($urandom % 4) != 0;
         end
         cycle();
      end

      idle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R5 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule